// File: doc/BRIEF.md
# Self-Modifying Accumulator Processor Core

This block is a small 8-bit accumulator processor. Code and data share one store of sixteen 8-bit cells, so a program can change its own instructions. Each cycle the core fetches the word addressed by its program counter, decodes it and executes it. Loading, storing, addition, subtraction, an equality test that skips the next instruction, jumping and halting are all supported. An operand is either a 4-bit immediate constant or the address of a cell.

The host fills the store through a loader port while the `hold` input keeps the core parked at address 0. It then drops `hold` and waits for `halted`. A combinational debug port reads any cell at any time, including while the core runs. An asynchronous active-low reset clears the core and the whole store. The reset is released synchronously, through a two-stage synchronizer.

Top module: `acc_cpu_core`

## Requirements
- R1: An instruction word holds the opcode in bits [7:5], the immediate flag in bit [4] and the operand field in bits [3:0]. The opcodes are: 000 halt, 001 load, 010 store, 011 add, 100 subtract, 101 equality test, 110 jump and 111 reserved.
- R2: The operand value is the zero-extended operand field when the immediate flag is 1, and the contents of the cell it addresses when the flag is 0. Load copies this value into the accumulator. Add and subtract combine it with the accumulator modulo 256.
- R3: Store writes the accumulator into the cell named by the operand field whatever the immediate flag is, even when that cell holds code. A later fetch or operand read of that cell returns the new word.
- R4: The equality test advances the program counter by 2 when the accumulator equals the operand value, and by 1 otherwise.
- R5: With the immediate flag set, jump loads the program counter with the operand field. With the flag clear, jump loads it with bits [3:0] of the addressed cell.
- R6: Executing halt sets `halted` at the next clock edge. From then on the program counter, the accumulator and the store keep their values until `hold` or reset.
- R7: The reserved opcode changes nothing except the program counter, which advances by 1. The program counter wraps from 15 to 0.
- R8: While `rst_n` is low, every cell reads zero and `halted` is 0. A cell that has not been written since reset reads zero.
- R9: While `hold` is high, the core stays at program counter 0 with accumulator 0, `halted` is cleared, and a high `ld_we` writes `ld_data` into cell `ld_addr`. While `hold` is low, `ld_we` has no effect.
- R10: `dbg_data` always shows the present contents of cell `dbg_addr`.
- R11: The core completes exactly one instruction per clock cycle while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the core and the store |
| hold | input | 1 | Parks the core at its start state and enables the loader |
| ld_we | input | 1 | Loader write strobe |
| ld_addr | input | 4 | Loader cell address |
| ld_data | input | 8 | Loader write data |
| dbg_addr | input | 4 | Debug read address |
| dbg_data | output | 8 | Contents of the addressed cell |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench runs a self-decrementing loop. In it, a subtract rewrites the constant of an equality test until the test matches and the program falls onto its halt. A core that fetched stale code would loop forever, and one that skipped on a mismatch would halt with the wrong tally. A second program stores a result whose opcode field reads as halt and then reaches it through an indirect jump through a reserved no-op. This exposes store and fetch ordering errors, wrong jump-target bits and a reserved opcode that acts. Other programs cover wrap of add and subtract, reads of never-written cells, loader strobes while running, and wrap of the program counter from 15 to 0. A design that mishandled any of these would show a different cell value or a different halt cycle.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 3'b000,
    OP_LOAD  = 3'b001,
    OP_STORE = 3'b010,
    OP_ADD   = 3'b011,
    OP_SUB   = 3'b100,
    OP_EQ    = 3'b101,
    OP_JUMP  = 3'b110,
    OP_RSVD  = 3'b111
  } opcode_e;

endpackage

// File: rtl/acc_cpu_mem.sv
`timescale 1ns/1ps
module acc_cpu_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              st_we,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] fetch_data,
  input  logic [ADDR_W-1:0] opnd_addr,
  output logic [DATA_W-1:0] opnd_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DEPTH-1:0]  wr_hit;

  // Loader owns the write port while the core is parked, the core otherwise.
  always_comb begin
    if (hold) begin
      wr_en   = ld_we;
      wr_addr = ld_addr;
      wr_data = ld_data;
    end else begin
      wr_en   = st_we;
      wr_addr = st_addr;
      wr_data = st_data;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign wr_hit[g] = wr_en && (wr_addr == ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_hit[i]) cell_q[i] <= wr_data;
      end
    end
  end

  assign fetch_data = cell_q[fetch_addr];
  assign opnd_data  = cell_q[opnd_addr];
  assign dbg_data   = cell_q[dbg_addr];

  // R3
  store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !hold) |=> (cell_q[$past(st_addr)] == $past(st_data)));

  // R9
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && ld_we) |=> (cell_q[$past(ld_addr)] == $past(ld_data)));

endmodule

// File: rtl/acc_cpu_decode.sv
`timescale 1ns/1ps
module acc_cpu_decode
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] opnd_data,
  output opcode_e           op,
  output logic [ADDR_W-1:0] field,
  output logic [DATA_W-1:0] opnd_val,
  output logic [ADDR_W-1:0] jump_tgt
);

  logic imm;

  assign op    = opcode_e'(instr[DATA_W-1 -: OP_W]);
  assign imm   = instr[ADDR_W];
  assign field = instr[ADDR_W-1:0];

  always_comb begin
    if (imm) begin
      opnd_val = {{(DATA_W-ADDR_W){1'b0}}, field};
      jump_tgt = field;
    end else begin
      opnd_val = opnd_data;
      jump_tgt = opnd_data[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/acc_cpu_ctrl.sv
`timescale 1ns/1ps
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  opcode_e           op,
  input  logic [DATA_W-1:0] opnd_val,
  input  logic [ADDR_W-1:0] jump_tgt,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic              halted,
  output logic              st_we
);

  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              halted_q, halted_d;
  logic              run_en;
  logic              is_match;

  assign run_en   = !hold && !halted_q;
  assign pc_inc   = pc_q + 1'b1;
  assign is_match = (acc_q == opnd_val);

  always_comb begin
    pc_d     = pc_inc;
    acc_d    = acc_q;
    halted_d = halted_q;
    st_we    = 1'b0;
    unique case (op)
      OP_HALT: begin
        pc_d     = pc_q;
        halted_d = 1'b1;
      end
      OP_LOAD:  acc_d = opnd_val;
      OP_STORE: st_we = run_en;
      OP_ADD:   acc_d = acc_q + opnd_val;
      OP_SUB:   acc_d = acc_q - opnd_val;
      OP_EQ:    if (is_match) pc_d = pc_q + ADDR_W'(2);
      OP_JUMP:  pc_d = jump_tgt;
      OP_RSVD:  pc_d = pc_inc;
      default:  pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      acc_q    <= '0;
      halted_q <= 1'b0;
    end else if (hold) begin
      pc_q     <= '0;
      acc_q    <= '0;
      halted_q <= 1'b0;
    end else if (run_en) begin
      pc_q     <= pc_d;
      acc_q    <= acc_d;
      halted_q <= halted_d;
    end
  end

  assign pc     = pc_q;
  assign acc    = acc_q;
  assign halted = halted_q;

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !hold) |=> (halted_q && $stable(pc_q) && $stable(acc_q)));

  // R9
  hold_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pc_q == '0 && acc_q == '0 && !halted_q));

  // R4
  eq_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && op == OP_EQ && acc_q == opnd_val) |=> (pc_q == $past(pc_q) + ADDR_W'(2)));

  // R7
  rsvd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && op == OP_RSVD) |=> (pc_q == $past(pc_q) + 1'b1 && $stable(acc_q)));

  // R5
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && op == OP_JUMP) |=> (pc_q == $past(jump_tgt)));

endmodule

// File: rtl/acc_cpu_core.sv
`timescale 1ns/1ps
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data,
  output logic              halted
);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] instr;
  logic [DATA_W-1:0] opnd_data;
  logic [DATA_W-1:0] opnd_val;
  logic [ADDR_W-1:0] field;
  logic [ADDR_W-1:0] jump_tgt;
  logic              st_we;
  opcode_e           op;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  acc_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .hold       (hold),
    .ld_we      (ld_we),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .st_we      (st_we),
    .st_addr    (field),
    .st_data    (acc),
    .fetch_addr (pc),
    .fetch_data (instr),
    .opnd_addr  (field),
    .opnd_data  (opnd_data),
    .dbg_addr   (dbg_addr),
    .dbg_data   (dbg_data)
  );

  acc_cpu_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .instr     (instr),
    .opnd_data (opnd_data),
    .op        (op),
    .field     (field),
    .opnd_val  (opnd_val),
    .jump_tgt  (jump_tgt)
  );

  acc_cpu_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .hold     (hold),
    .op       (op),
    .opnd_val (opnd_val),
    .jump_tgt (jump_tgt),
    .pc       (pc),
    .acc      (acc),
    .halted   (halted),
    .st_we    (st_we)
  );

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    (!rst_n) |-> (!halted && dbg_data == '0));

endmodule

// File: tb/acc_cpu_core_tb.sv
`timescale 1ns/1ps
module acc_cpu_core_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hold;
  logic       ld_we;
  logic [3:0] ld_addr;
  logic [7:0] ld_data;
  logic [3:0] dbg_addr;
  logic [7:0] dbg_data;
  logic       halted;

  int vecs  = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  bit sweep  = 1'b1;
  bit done   = 1'b0;

  int m_mem [16];
  int m_pc, m_acc;
  bit m_halt;

  always #10 clk = ~clk;

  acc_cpu_core u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .ld_we    (ld_we),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data),
    .halted   (halted)
  );

  // Behavioural reference: one instruction per edge (R11).
  always @(posedge clk or negedge rst_n) begin
    int ins, op, imm, f, v;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_mem[i] = 0;
      m_pc = 0; m_acc = 0; m_halt = 0;
    end else if (hold) begin
      m_pc = 0; m_acc = 0; m_halt = 0;
      if (ld_we) m_mem[ld_addr] = ld_data;
    end else if (!m_halt) begin
      ins = m_mem[m_pc];
      op  = ins >> 5;
      imm = (ins >> 4) & 1;
      f   = ins & 15;
      v   = imm ? f : m_mem[f];
      case (op)
        0: m_halt = 1;
        1: begin m_acc = v; m_pc = (m_pc + 1) & 15; end
        2: begin m_mem[f] = m_acc; m_pc = (m_pc + 1) & 15; end
        3: begin m_acc = (m_acc + v) & 255; m_pc = (m_pc + 1) & 15; end
        4: begin m_acc = (m_acc - v) & 255; m_pc = (m_pc + 1) & 15; end
        5: m_pc = (m_pc + ((m_acc == v) ? 2 : 1)) & 15;
        6: m_pc = v & 15;
        default: m_pc = (m_pc + 1) & 15;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference model.
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R10 debug read vs model", dbg_data, m_mem[dbg_addr]);
      chk("R6 halted vs model", halted, m_halt);
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    if (sweep) dbg_addr = dbg_addr + 4'd1;
  endtask

  task automatic do_reset();
    tick();
    rst_n = 1'b0; hold = 1'b1; ld_we = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic load(input int a, input int d);
    ld_we = 1'b1; ld_addr = 4'(a); ld_data = 8'(d);
    tick();
    ld_we = 1'b0;
  endtask

  task automatic peek(input string tag, input int a, input int exp);
    sweep = 1'b0;
    dbg_addr = 4'(a);
    #1;
    chk(tag, dbg_data, exp);
  endtask

  task automatic run_until_halt(input int max, output int n);
    n = 0;
    while (!halted && n < max) begin
      tick();
      n++;
    end
    if (!halted) begin
      fails++;
      $display("FAIL R6 watchdog: program did not halt, actual %0d cycles expected < %0d", n, max);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    rst_n = 1'b0; hold = 1'b1; ld_we = 1'b0;
    ld_addr = '0; ld_data = '0; dbg_addr = '0;
    #5;
    // R8: state while reset is held
    chk("R8 halted during reset", halted, 0);
    do_reset();
    cmp_on = 1'b1;
    for (int i = 0; i < 16; i++) peek("R8 cell zero after reset", i, 0);
    sweep = 1'b1;

    // Self-decrementing loop (R1 R2 R3 R4 R5 R11)
    load(0, 8'h31); load(1, 8'h4F); load(2, 8'h30); load(3, 8'hB4);
    load(4, 8'hD6); load(5, 8'h00); load(6, 8'h23); load(7, 8'h91);
    load(8, 8'h43); load(9, 8'h2F); load(10, 8'h6F); load(11, 8'h4F);
    load(12, 8'hD2);
    hold = 1'b0;
    run_until_halt(500, n);
    chk("R11 cycles to halt", n, 45);
    peek("R2 doubled tally in cell 15", 15, 8'h10);
    peek("R3 rewritten test word in cell 3", 3, 8'hB0);
    sweep = 1'b1;
    repeat (20) tick();
    chk("R6 halted stays", halted, 1);
    peek("R6 store frozen after halt", 15, 8'h10);

    // Fresh reset clears the store (R8)
    sweep = 1'b1;
    do_reset();
    peek("R8 cell 15 cleared", 15, 0);
    peek("R8 cell 3 cleared", 3, 0);
    sweep = 1'b1;

    // Wrap, unwritten cell, indirect jump, ignored loader (R2 R3 R5 R7 R9)
    load(0, 8'h3F); load(1, 8'h6A); load(2, 8'h4B); load(3, 8'h30);
    load(4, 8'h91); load(5, 8'h4C); load(6, 8'h2D); load(7, 8'h73);
    load(8, 8'h4E); load(9, 8'hCF); load(10, 8'hF8); load(15, 8'h1A);
    hold = 1'b0;
    ld_we = 1'b1; ld_addr = 4'd5; ld_data = 8'h77;
    tick();
    ld_we = 1'b0;
    run_until_halt(500, n);
    peek("R2 add wraps to 0x07", 11, 8'h07);
    peek("R2 subtract wraps to 0xFF", 12, 8'hFF);
    peek("R8 unwritten cell read as zero", 14, 8'h03);
    peek("R9 loader ignored while running", 5, 8'h4C);
    peek("R7 reserved word untouched", 10, 8'hF8);
    sweep = 1'b1;

    // Hold without reset clears halted (R9)
    hold = 1'b1;
    tick();
    chk("R9 hold clears halted", halted, 0);
    // PC wrap and equality both ways (R4 R7)
    load(0, 8'hB8); load(1, 8'hDD); load(2, 8'h00);
    load(13, 8'h71); load(14, 8'h4C); load(15, 8'hE0);
    hold = 1'b0;
    run_until_halt(500, n);
    chk("R7 cycles through wrap loop", n, 42);
    peek("R4 loop count in cell 12", 12, 8'h08);
    sweep = 1'b1;
    repeat (4) tick();

    cmp_on = 1'b0;
    summary();
  end

endmodule